// File: doc/BRIEF.md
# I2C control register bank for a two-channel step-down regulator

This block is the serial control target of a dual voltage regulator. A controller on a two-wire I2C bus selects the device at 7-bit address 0x21. It writes one of three control registers, or reads one back. The stored fields leave the block as plain control pins: channel enables, spread-spectrum on/off and modulation rate, per-channel voltage ramp enables, a 5-bit voltage code per channel, per-channel forced-PWM selects, and a disable for the output-level reset monitor.

SCL and SDA are sampled by a much faster system clock. They pass through a synchronizer, and START, STOP and clock edges are found by comparing samples. SDA is driven open-drain: `sda_o` is always 0, and `sda_oe` pulls the line low. Each transaction moves a single data byte. A read is an index write, then a repeated START with the read address, then one byte sent by the target. Voltage codes with no defined voltage are refused field by field.

There is no streaming interface. Bus pins and register fields are plain level signals, so no back-pressure rules apply.

Top module: `dvr_ctrl_regs`

## Requirements
- R1: After reset, the outputs are as follows:
  - `ch1_en`=1, `ch2_en`=1, `ss_en`=0, `ss_rate_1k`=1, both ramp enables 0.
  - `ch1_vcode`=CH1_CODE_RST (default 9) and `ch2_vcode`=CH2_CODE_RST (default 8).
  - Both forced-PWM selects are 0 and `mon_disable`=0.
  - `sda_oe`=0.
- R2: Address bytes are sent MSB first, with bit 0 giving the direction (0 write, 1 read). An address byte whose upper 7 bits equal 0x21 is acknowledged, meaning SDA is held low during the 9th SCL pulse. Any other address gets no acknowledge. After such an address every following byte is ignored and not acknowledged until the next START.
- R3: A write is START, address 0x42, register index, data byte, STOP. The target acknowledges all three bytes, and the addressed register takes the data.
- R4: Register index 0 holds the control fields:
  - bit0 `ch1_en`, bit1 `ch2_en`, bit2 `ss_en`
  - bit3 `ss_rate_1k` (1 = 1 kHz, 0 = 2 kHz)
  - bit4 `ch1_ramp_en`, bit5 `ch2_ramp_en`
  - bits 7:6 are unused.
- R5: Register index 1 holds `ch1_vcode` in bits 4:0 and `ch1_fpwm` in bit5. The valid code range is 5 to 25 inclusive.
- R6: Register index 2 holds `ch2_vcode` in bits 4:0, `ch2_fpwm` in bit5 and `mon_disable` in bit6. The valid code range is 1 to 16 inclusive.
- R7: If a written code is outside its channel's range, the old code is kept. The other fields of that same data byte are still stored.
- R8: A write to an index above 2 is acknowledged and has no effect on any register.
- R9: A read is START, 0x42, index, repeated START, 0x43, then one byte sent MSB first by the target. The byte returns the register value with unused bits at 0. An index above 2 returns 0x00.
- R10: The target raises `sda_oe` only while SCL is low. It releases SDA outside acknowledge slots and read data bits.
- R11: A write takes exactly one data byte. A further byte before STOP is not acknowledged and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples SCL and SDA |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as sampled |
| sda_i | input | 1 | I2C data line as sampled |
| sda_o | output | 1 | Data line output value, always 0 |
| sda_oe | output | 1 | 1 pulls SDA low |
| ch1_en | output | 1 | Channel 1 enable |
| ch2_en | output | 1 | Channel 2 enable |
| ss_en | output | 1 | Spread-spectrum enable |
| ss_rate_1k | output | 1 | Modulation rate, 1 = 1 kHz, 0 = 2 kHz |
| ch1_ramp_en | output | 1 | Channel 1 stepped voltage ramp enable |
| ch2_ramp_en | output | 1 | Channel 2 stepped voltage ramp enable |
| ch1_vcode | output | 5 | Channel 1 output voltage code |
| ch2_vcode | output | 5 | Channel 2 output voltage code |
| ch1_fpwm | output | 1 | Channel 1 forced-PWM select |
| ch2_fpwm | output | 1 | Channel 2 forced-PWM select |
| mon_disable | output | 1 | Output-level reset monitor disable |

## Verification
The hardest case to reach from the pins is the turn of a read. The target first acknowledges the index byte. It must release SDA before the controller's repeated START. It then acknowledges the read address and drives data bit 7 on the same falling SCL edge that ends that acknowledge. The bench builds this with a START task that works from SCL low, and samples every bit at mid-high. It also sends data bytes that pair a rejected voltage code with valid neighbouring fields, and full byte streams after a foreign address, and then checks that every field pin stays as the requirements predict.

// File: rtl/dvr_regs_pkg.sv
package dvr_regs_pkg;

  typedef enum logic [2:0] {
    BS_IDLE,
    BS_ADDR,
    BS_INDEX,
    BS_DATA,
    BS_SEND,
    BS_SKIP
  } bus_state_e;

  localparam int BYTE_W = 8;
  localparam int CODE_W = 5;

  function automatic logic code_in_range(input logic [CODE_W-1:0] code,
                                         input logic [CODE_W-1:0] lo,
                                         input logic [CODE_W-1:0] hi);
    return (code >= lo) && (code <= hi);
  endfunction

endpackage

// File: rtl/dvr_pin_sync.sv
module dvr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] scl_chain, sda_chain;
  logic          scl_prev, sda_prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= scl_i;
          sda_chain <= sda_i;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= {scl_chain[LAST-1:0], scl_i};
          sda_chain <= {sda_chain[LAST-1:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_chain[LAST];
      sda_prev <= sda_chain[LAST];
    end
  end

  assign scl_lvl   = scl_chain[LAST];
  assign sda_lvl   = sda_chain[LAST];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/dvr_bus_target.sv
module dvr_bus_target
  import dvr_regs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] reg_ptr,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  bus_state_e        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic              in_ack;
  logic              rw_bit;
  logic [BYTE_W-1:0] shreg;
  logic              rx_phase;

  assign rx_phase = (state == BS_ADDR) || (state == BS_INDEX) || (state == BS_DATA);
  assign wr_data  = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= BS_IDLE;
      bit_cnt  <= '0;
      in_ack   <= 1'b0;
      rw_bit   <= 1'b0;
      shreg    <= '0;
      reg_ptr  <= '0;
      sda_oe   <= 1'b0;
      wr_valid <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      if (start_evt) begin
        state   <= BS_ADDR;
        bit_cnt <= '0;
        in_ack  <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (stop_evt) begin
        state  <= BS_IDLE;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (scl_rise) begin
        if (state == BS_SEND) begin
          bit_cnt <= bit_cnt + 1'b1;
        end else if (rx_phase && !in_ack && bit_cnt != FULL) begin
          shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (scl_fall) begin
        if (state == BS_SEND) begin
          if (bit_cnt == FULL) begin
            sda_oe <= 1'b0;
            state  <= BS_SKIP;
          end else begin
            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
            sda_oe <= ~shreg[BYTE_W-2];
          end
        end else if (rx_phase && in_ack) begin
          in_ack  <= 1'b0;
          sda_oe  <= 1'b0;
          bit_cnt <= '0;
          case (state)
            BS_ADDR: begin
              if (rw_bit) begin
                state  <= BS_SEND;
                shreg  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
              end else begin
                state <= BS_INDEX;
              end
            end
            BS_INDEX: state <= BS_DATA;
            default:  state <= BS_SKIP;
          endcase
        end else if (rx_phase && bit_cnt == FULL) begin
          case (state)
            BS_ADDR: begin
              if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                rw_bit <= shreg[0];
                in_ack <= 1'b1;
                sda_oe <= 1'b1;
              end else begin
                state <= BS_SKIP;
              end
            end
            BS_INDEX: begin
              reg_ptr <= shreg;
              in_ack  <= 1'b1;
              sda_oe  <= 1'b1;
            end
            default: begin
              wr_valid <= 1'b1;
              in_ack   <= 1'b1;
              sda_oe   <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  // R10: the line is never pulled while the byte engine is idle
  p_oe_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == BS_IDLE) |-> !sda_oe);

  // R10: the target starts pulling SDA only while SCL is low
  p_oe_rise_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);

  // R2: a foreign address leaves the line released and the engine skipping
  p_nack_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && state == BS_ADDR && !in_ack && bit_cnt == FULL &&
     shreg[BYTE_W-1:1] != DEV_ADDR) |=> (state == BS_SKIP && !sda_oe));

  // R11: one data byte per write transaction
  p_single_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

endmodule

// File: rtl/dvr_reg_bank.sv
module dvr_reg_bank
  import dvr_regs_pkg::*;
#(
  parameter logic [CODE_W-1:0] CH1_CODE_MIN = 5'd5,
  parameter logic [CODE_W-1:0] CH1_CODE_MAX = 5'd25,
  parameter logic [CODE_W-1:0] CH2_CODE_MIN = 5'd1,
  parameter logic [CODE_W-1:0] CH2_CODE_MAX = 5'd16,
  parameter logic [CODE_W-1:0] CH1_CODE_RST = 5'd9,
  parameter logic [CODE_W-1:0] CH2_CODE_RST = 5'd8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] rd_idx,
  output logic [BYTE_W-1:0] rd_data,
  output logic [5:0]        ctrl_q,
  output logic [5:0]        ch1_q,
  output logic [6:0]        ch2_q
);
  localparam logic [5:0] CTRL_RST = 6'b00_1011;
  localparam logic [5:0] CH1_RST  = {1'b0, CH1_CODE_RST};
  localparam logic [6:0] CH2_RST  = {2'b00, CH2_CODE_RST};

  logic ch1_ok, ch2_ok;

  assign ch1_ok = code_in_range(wr_data[CODE_W-1:0], CH1_CODE_MIN, CH1_CODE_MAX);
  assign ch2_ok = code_in_range(wr_data[CODE_W-1:0], CH2_CODE_MIN, CH2_CODE_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      ch1_q  <= CH1_RST;
      ch2_q  <= CH2_RST;
    end else if (wr_valid) begin
      case (wr_idx)
        8'd0: ctrl_q <= wr_data[5:0];
        8'd1: begin
          ch1_q[5] <= wr_data[5];
          if (ch1_ok) ch1_q[4:0] <= wr_data[4:0];
        end
        8'd2: begin
          ch2_q[6:5] <= wr_data[6:5];
          if (ch2_ok) ch2_q[4:0] <= wr_data[4:0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_idx)
      8'd0:    rd_data = {2'b00, ctrl_q};
      8'd1:    rd_data = {2'b00, ch1_q};
      8'd2:    rd_data = {1'b0, ch2_q};
      default: rd_data = '0;
    endcase
  end

  p_code1_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ch1_q[4:0] >= CH1_CODE_MIN) && (ch1_q[4:0] <= CH1_CODE_MAX));

  p_code2_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ch2_q[4:0] >= CH2_CODE_MIN) && (ch2_q[4:0] <= CH2_CODE_MAX));

  p_keep_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_idx == 8'd1 && !ch1_ok) |=> $stable(ch1_q[4:0]));

  p_discard_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_idx > 8'd2) |=> $stable({ctrl_q, ch1_q, ch2_q}));

endmodule

// File: rtl/dvr_ctrl_regs.sv
module dvr_ctrl_regs
  import dvr_regs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR     = 7'h21,
  parameter int         SYNC_STAGES  = 2,
  parameter logic [4:0] CH1_CODE_MIN = 5'd5,
  parameter logic [4:0] CH1_CODE_MAX = 5'd25,
  parameter logic [4:0] CH2_CODE_MIN = 5'd1,
  parameter logic [4:0] CH2_CODE_MAX = 5'd16,
  parameter logic [4:0] CH1_CODE_RST = 5'd9,
  parameter logic [4:0] CH2_CODE_RST = 5'd8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_o,
  output logic       sda_oe,
  output logic       ch1_en,
  output logic       ch2_en,
  output logic       ss_en,
  output logic       ss_rate_1k,
  output logic       ch1_ramp_en,
  output logic       ch2_ramp_en,
  output logic [4:0] ch1_vcode,
  output logic [4:0] ch2_vcode,
  output logic       ch1_fpwm,
  output logic       ch2_fpwm,
  output logic       mon_disable
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic [BYTE_W-1:0] reg_ptr, wr_data, rd_data;
  logic wr_valid;
  logic [5:0] ctrl_q, ch1_q;
  logic [6:0] ch2_q;

  dvr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
  );

  dvr_bus_target #(.DEV_ADDR(DEV_ADDR)) u_target (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_evt(start_evt),
    .stop_evt(stop_evt), .rd_data(rd_data), .reg_ptr(reg_ptr),
    .wr_valid(wr_valid), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  dvr_reg_bank #(
    .CH1_CODE_MIN(CH1_CODE_MIN), .CH1_CODE_MAX(CH1_CODE_MAX),
    .CH2_CODE_MIN(CH2_CODE_MIN), .CH2_CODE_MAX(CH2_CODE_MAX),
    .CH1_CODE_RST(CH1_CODE_RST), .CH2_CODE_RST(CH2_CODE_RST)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_idx(reg_ptr),
    .wr_data(wr_data), .rd_idx(reg_ptr), .rd_data(rd_data),
    .ctrl_q(ctrl_q), .ch1_q(ch1_q), .ch2_q(ch2_q)
  );

  assign sda_o       = 1'b0;
  assign ch1_en      = ctrl_q[0];
  assign ch2_en      = ctrl_q[1];
  assign ss_en       = ctrl_q[2];
  assign ss_rate_1k  = ctrl_q[3];
  assign ch1_ramp_en = ctrl_q[4];
  assign ch2_ramp_en = ctrl_q[5];
  assign ch1_vcode   = ch1_q[4:0];
  assign ch1_fpwm    = ch1_q[5];
  assign ch2_vcode   = ch2_q[4:0];
  assign ch2_fpwm    = ch2_q[5];
  assign mon_disable = ch2_q[6];

endmodule

// File: tb/dvr_ctrl_regs_bench.sv
`timescale 1ns/1ps
module dvr_ctrl_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic tb_sda = 1'b1;
  logic sda_o, sda_oe;
  logic ch1_en, ch2_en, ss_en, ss_rate_1k, ch1_ramp_en, ch2_ramp_en;
  logic [4:0] ch1_vcode, ch2_vcode;
  logic ch1_fpwm, ch2_fpwm, mon_disable;
  wire  sda_bus = tb_sda & ~(sda_oe & ~sda_o);

  int vectors = 0;
  int misses = 0;
  bit done = 0;

  logic [5:0] m_ctrl;
  logic [5:0] m_ch1;
  logic [6:0] m_ch2;

  always #2.5 clk = ~clk;

  dvr_ctrl_regs u_dvr_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_o(sda_o), .sda_oe(sda_oe), .ch1_en(ch1_en), .ch2_en(ch2_en),
    .ss_en(ss_en), .ss_rate_1k(ss_rate_1k), .ch1_ramp_en(ch1_ramp_en),
    .ch2_ramp_en(ch2_ramp_en), .ch1_vcode(ch1_vcode), .ch2_vcode(ch2_vcode),
    .ch1_fpwm(ch1_fpwm), .ch2_fpwm(ch2_fpwm), .mon_disable(mon_disable)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hq();
    repeat (10) @(negedge clk);
  endtask

  task automatic bus_start();
    hq(); tb_sda = 1'b1; hq(); scl = 1'b1; hq(); tb_sda = 1'b0; hq(); scl = 1'b0;
  endtask

  task automatic bus_stop();
    hq(); tb_sda = 1'b0; hq(); scl = 1'b1; hq(); tb_sda = 1'b1; hq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      hq(); tb_sda = b[i]; hq(); scl = 1'b1; hq(); hq(); scl = 1'b0;
    end
    hq(); tb_sda = 1'b1; hq(); scl = 1'b1; hq();
    acked = (sda_bus == 1'b0);
    hq(); scl = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b);
    b = '0;
    tb_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hq(); hq(); scl = 1'b1; hq();
      b = {b[6:0], sda_bus};
      hq(); scl = 1'b0;
    end
    hq(); tb_sda = 1'b1; hq(); scl = 1'b1; hq(); hq(); scl = 1'b0;
  endtask

  function automatic void model_write(input logic [7:0] idx, input logic [7:0] d);
    case (idx)
      8'd0: m_ctrl = d[5:0];
      8'd1: begin
        m_ch1[5] = d[5];
        if (d[4:0] >= 5 && d[4:0] <= 25) m_ch1[4:0] = d[4:0];
      end
      8'd2: begin
        m_ch2[6:5] = d[6:5];
        if (d[4:0] >= 1 && d[4:0] <= 16) m_ch2[4:0] = d[4:0];
      end
      default: ;
    endcase
  endfunction

  task automatic check_fields(input string req);
    chk({req, " ctrl"}, {ch2_ramp_en, ch1_ramp_en, ss_rate_1k, ss_en, ch2_en, ch1_en}, m_ctrl);
    chk({req, " ch1"}, {ch1_fpwm, ch1_vcode}, m_ch1);
    chk({req, " ch2"}, {mon_disable, ch2_fpwm, ch2_vcode}, m_ch2);
  endtask

  task automatic write_reg(input string req, input logic [7:0] idx, input logic [7:0] d);
    bit a0, a1, a2;
    bus_start();
    send_byte(8'h42, a0);
    send_byte(idx, a1);
    send_byte(d, a2);
    bus_stop();
    chk({req, " acks"}, {a0, a1, a2}, 3'b111);
    model_write(idx, d);
    check_fields(req);
  endtask

  task automatic read_reg(input string req, input logic [7:0] idx, input logic [7:0] exp);
    bit a0, a1, a2;
    logic [7:0] d;
    bus_start();
    send_byte(8'h42, a0);
    send_byte(idx, a1);
    bus_start();
    send_byte(8'h43, a2);
    recv_byte(d);
    bus_stop();
    chk({req, " read acks"}, {a0, a1, a2}, 3'b111);
    chk({req, " read data"}, d, exp);
  endtask

  task automatic t_reset();
    m_ctrl = 6'b00_1011; m_ch1 = 6'd9; m_ch2 = 7'd8;
    check_fields("R1 reset");
    chk("R1 sda_oe at reset", sda_oe, 0);
    chk("R10 sda_o tie", sda_o, 0);
  endtask

  task automatic t_ctrl_write();
    write_reg("R3 R4 ctrl 0x34", 8'd0, 8'h34);
    write_reg("R4 ctrl 0xCB", 8'd0, 8'hCB);
  endtask

  task automatic t_ch1_codes();
    write_reg("R5 ch1 max", 8'd1, 8'h39);
    write_reg("R5 ch1 min", 8'd1, 8'h05);
    write_reg("R7 ch1 code 4 kept", 8'd1, 8'h24);
    write_reg("R7 ch1 code 26 kept", 8'd1, 8'h1A);
  endtask

  task automatic t_ch2_codes();
    write_reg("R6 ch2 max", 8'd2, 8'h70);
    write_reg("R7 ch2 code 0 kept", 8'd2, 8'h40);
    write_reg("R7 ch2 code 17 kept", 8'd2, 8'h11);
    write_reg("R6 ch2 min", 8'd2, 8'h01);
  endtask

  task automatic t_bad_index();
    write_reg("R8 index 3", 8'd3, 8'hFF);
    write_reg("R8 index 0xFF", 8'hFF, 8'h00);
  endtask

  task automatic t_reads();
    write_reg("R9 setup", 8'd0, 8'hFF);
    read_reg("R9 reg0 unused zero", 8'd0, {2'b00, m_ctrl});
    read_reg("R9 reg1", 8'd1, {2'b00, m_ch1});
    write_reg("R9 setup2", 8'd2, 8'hCA);
    read_reg("R9 reg2", 8'd2, {1'b0, m_ch2});
    read_reg("R9 index 5", 8'd5, 8'h00);
  endtask

  task automatic t_wrong_addr();
    bit a0, a1, a2;
    bus_start();
    send_byte(8'h44, a0);
    send_byte(8'd0, a1);
    send_byte(8'h00, a2);
    bus_stop();
    chk("R2 foreign address no acks", {a0, a1, a2}, 3'b000);
    check_fields("R2 foreign address ignored");
    bus_start();
    send_byte(8'h42, a0);
    send_byte(8'd1, a1);
    send_byte(8'h0C, a2);
    bus_start();
    send_byte(8'h46, a0);
    send_byte(8'h2A, a1);
    bus_stop();
    chk("R2 second address after restart", {a0, a1}, 2'b00);
    model_write(8'd1, 8'h0C);
    check_fields("R2 write before foreign restart");
  endtask

  task automatic t_no_autoinc();
    bit a0, a1, a2, a3;
    bus_start();
    send_byte(8'h42, a0);
    send_byte(8'd0, a1);
    send_byte(8'h0F, a2);
    send_byte(8'h30, a3);
    bus_stop();
    chk("R11 first three acked", {a0, a1, a2}, 3'b111);
    chk("R11 extra byte not acked", a3, 0);
    model_write(8'd0, 8'h0F);
    check_fields("R11 extra byte no effect");
    chk("R10 released after stop", sda_oe, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_ctrl_write();
    t_ch1_codes();
    t_ch2_codes();
    t_bad_index();
    t_reads();
    t_wrong_addr();
    t_no_autoinc();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++;
      misses++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule